// File: doc/BRIEF.md
# Four-Channel Block-Transfer DMA Engine

This block moves blocks of halfwords or words from one address range to another on behalf of a processor. It holds four channels. Each channel has a programmed source address, destination address, unit count and 16-bit control word. A channel starts as soon as its enable bit rises, or it waits for a vertical-blank pulse, a horizontal-blank pulse or a per-channel special trigger. Every unit is one read on a synchronous request/ready memory port, followed by one write of the returned data.

Software programs a channel through a single-cycle write port. `reg_sel` chooses the register and `reg_ch` chooses the channel. Source and destination addresses step up or down, stay fixed, or step up and return to their start on each repeat. When a block completes, a non-repeating channel disarms itself. A repeating channel reloads its count and waits for its next trigger. Each channel can raise a one-cycle completion interrupt.

Only one channel transfers at a time. Pending channels are granted lowest number first, and a granted channel runs its whole block before any other channel is granted.

Top module: `blkxfer_dma`

## Requirements
- R1: While `rst_n` is low, and after it is released with no writes, `mem_req` is 0, `irq` is 0 and every control word read on `ctrl_o` is 0.
- R2: A write with `reg_sel`=0 (source) or `reg_sel`=1 (destination) stores the address with bit 0 forced to 0. During word transfers (control bit 10 = 1) every address on `mem_addr` has bits 1:0 at 0. During halfword transfers (bit 10 = 0) bit 0 is 0.
- R3: Address control fields sit in control bits 6:5 (destination) and 8:7 (source). Code 0 steps up, 1 steps down, 2 holds the address, and 3 steps up. The step is 2 bytes for halfwords and 4 bytes for words.
- R4: A programmed count of 0 (`reg_sel`=2) means 2^(CNT_W-2) units on channels 0, 1 and 2, and 2^CNT_W units on channel 3. With the defaults these are 0x4000 and 0x10000.
- R5: A control write (`reg_sel`=3) latches source, destination and count into the channel's working state only when bit 15 (enable) goes from 0 to 1. Rewriting the control word while enable is already 1 restarts nothing. Writing enable as 0 cancels a pending start.
- R6: Control bits 13:12 give the start timing: 0 starts at once, 1 waits for `vblank`, 2 waits for `hblank`, 3 waits for the special trigger. When a blank pulse arrives, every enabled channel with the matching timing runs, channel 0 first and channel 3 last. A channel that is waiting makes no memory request.
- R7: Timing 3 on channel 0 is never started by any input. On channel n (1 to 3), timing 3 starts on `spec_trig[n-1]`.
- R8: When a block ends and repeat (bit 9) is 0, the control word clears bit 15 and bits 4:0 and keeps every other bit.
- R9: When a block ends and repeat is 1, the channel stays enabled and reloads its count. The source carries on from where it stopped. The destination carries on as well, unless its control is 3, in which case it returns to the programmed destination. The channel then waits for its next trigger.
- R10: When control bit 14 is 1, `irq[n]` pulses high for exactly one cycle, in the cycle after the final write handshake of channel n's block. When bit 14 is 0, `irq[n]` stays low.
- R11: The lowest-numbered pending channel is granted first. A granted channel completes all its units before any other channel makes a request.
- R12: Each unit is a read (`mem_we`=0) followed by a write (`mem_we`=1) to the destination. Request, address and direction hold steady until `mem_ready`. A word write carries the whole read data. A halfword write carries read data bits 15:0, zero-extended.
- R13: A control write is visible at once on `ctrl_o[16n+15:16n]` for channel n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_ch | input | 2 | Channel selected by the write |
| reg_sel | input | 2 | 0 source, 1 destination, 2 count, 3 control |
| reg_wdata | input | AW | Write data |
| ctrl_o | output | 64 | Four control words, channel n at bits 16n+15:16n |
| vblank | input | 1 | Vertical-blank start pulse |
| hblank | input | 1 | Horizontal-blank start pulse |
| spec_trig | input | 3 | Special start pulses for channels 1 to 3 |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_word | output | 1 | 1 for word access, 0 for halfword |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | DW | Write data |
| mem_ready | input | 1 | Memory accepts or answers the request |
| mem_rdata | input | DW | Read data, valid with `mem_ready` on a read |
| irq | output | 4 | Per-channel completion pulse |

## Verification
The bench builds the engine with CNT_W = 6, so a zero count becomes 16 units on channels 0 to 2 and 64 units on channel 3. This makes both maximum-length blocks cheap enough to run in full and compare unit by unit. It sweeps every channel against every source and destination address mode and both widths, using odd starting addresses and a memory that sometimes withholds ready. Expected addresses and data are computed from the starting values. Separate runs cover blank and special triggers, repeat reload, rewrites of an enable that is already set, and a channel being refused the bus while another is transferring.

// File: rtl/blkxfer_dma.sv
module blkxfer_dma #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int CNT_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic [1:0]      reg_ch,
  input  logic [1:0]      reg_sel,
  input  logic [AW-1:0]   reg_wdata,
  output logic [63:0]     ctrl_o,
  input  logic            vblank,
  input  logic            hblank,
  input  logic [2:0]      spec_trig,
  output logic            mem_req,
  output logic            mem_we,
  output logic            mem_word,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic            mem_ready,
  input  logic [DW-1:0]   mem_rdata,
  output logic [3:0]      irq
);
  localparam int NCH = 4;
  localparam int CW  = 16;
  localparam logic [CNT_W:0] MAX_LO = (CNT_W+1)'(1) << (CNT_W-2);
  localparam logic [CNT_W:0] MAX_HI = (CNT_W+1)'(1) << CNT_W;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR} st_t;

  logic [AW-1:0]    src_q [NCH];
  logic [AW-1:0]    dst_q [NCH];
  logic [AW-1:0]    src_w [NCH];
  logic [AW-1:0]    dst_w [NCH];
  logic [CNT_W-1:0] cnt_q [NCH];
  logic [CNT_W:0]   cnt_w [NCH];
  logic [CW-1:0]    ctl_q [NCH];
  logic [NCH-1:0]   pend_q, irq_q, fire;
  logic [NCH-1:0]   spec_v;
  logic [1:0]       cur_q, pick;
  logic [DW-1:0]    hold_q;
  st_t              st_q;

  logic       cur_word, cur_rep, cur_ie, last;
  logic [1:0] cur_sc, cur_dc, cur_tm;
  logic [AW-1:0] a_raw;

  function automatic logic [CNT_W:0] eff_cnt(input logic [1:0] ch, input logic [CNT_W-1:0] c);
    if (c != '0) return {1'b0, c};
    return (ch == 2'd3) ? MAX_HI : MAX_LO;
  endfunction

  function automatic logic [AW-1:0] stride(input logic [1:0] mode, input logic word);
    logic [AW-1:0] sz;
    sz = word ? AW'(4) : AW'(2);
    case (mode)
      2'd1:    return -sz;
      2'd2:    return '0;
      default: return sz;
    endcase
  endfunction

  assign spec_v   = {spec_trig, 1'b0};
  assign cur_word = ctl_q[cur_q][10];
  assign cur_rep  = ctl_q[cur_q][9];
  assign cur_ie   = ctl_q[cur_q][14];
  assign cur_sc   = ctl_q[cur_q][8:7];
  assign cur_dc   = ctl_q[cur_q][6:5];
  assign cur_tm   = ctl_q[cur_q][13:12];
  assign last     = (cnt_w[cur_q] == (CNT_W+1)'(1));

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      fire[i] = ctl_q[i][15] &&
                ((vblank    && ctl_q[i][13:12] == 2'd1) ||
                 (hblank    && ctl_q[i][13:12] == 2'd2) ||
                 (spec_v[i] && ctl_q[i][13:12] == 2'd3));
    end
  end

  always_comb begin
    pick = '0;
    for (int i = NCH-1; i >= 0; i--) begin
      if (pend_q[i]) pick = 2'(i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      cur_q  <= '0;
      hold_q <= '0;
      pend_q <= '0;
      irq_q  <= '0;
      for (int i = 0; i < NCH; i++) begin
        src_q[i] <= '0;
        dst_q[i] <= '0;
        src_w[i] <= '0;
        dst_w[i] <= '0;
        cnt_q[i] <= '0;
        cnt_w[i] <= '0;
        ctl_q[i] <= '0;
      end
    end else begin
      irq_q  <= '0;
      pend_q <= pend_q | fire;
      case (st_q)
        S_IDLE: begin
          if (|pend_q) begin
            cur_q        <= pick;
            pend_q[pick] <= 1'b0;
            st_q         <= S_RD;
          end
        end
        S_RD: begin
          if (mem_ready) begin
            hold_q <= mem_rdata;
            st_q   <= S_WR;
          end
        end
        S_WR: begin
          if (mem_ready) begin
            src_w[cur_q] <= src_w[cur_q] + stride(cur_sc, cur_word);
            dst_w[cur_q] <= dst_w[cur_q] + stride(cur_dc, cur_word);
            cnt_w[cur_q] <= cnt_w[cur_q] - 1'b1;
            st_q         <= last ? S_IDLE : S_RD;
            if (last) begin
              irq_q[cur_q] <= cur_ie;
              if (cur_rep) begin
                cnt_w[cur_q] <= eff_cnt(cur_q, cnt_q[cur_q]);
                if (cur_dc == 2'd3) dst_w[cur_q] <= dst_q[cur_q];
                if (cur_tm == 2'd0) pend_q[cur_q] <= 1'b1;
              end else begin
                ctl_q[cur_q][15]  <= 1'b0;
                ctl_q[cur_q][4:0] <= '0;
              end
            end
          end
        end
        default: st_q <= S_IDLE;
      endcase
      if (reg_we) begin
        case (reg_sel)
          2'd0: src_q[reg_ch] <= reg_wdata & ~AW'(1);
          2'd1: dst_q[reg_ch] <= reg_wdata & ~AW'(1);
          2'd2: cnt_q[reg_ch] <= reg_wdata[CNT_W-1:0];
          default: begin
            ctl_q[reg_ch] <= reg_wdata[CW-1:0];
            if (!reg_wdata[15]) begin
              pend_q[reg_ch] <= 1'b0;
            end else if (!ctl_q[reg_ch][15]) begin
              src_w[reg_ch]  <= src_q[reg_ch];
              dst_w[reg_ch]  <= dst_q[reg_ch];
              cnt_w[reg_ch]  <= eff_cnt(reg_ch, cnt_q[reg_ch]);
              pend_q[reg_ch] <= (reg_wdata[13:12] == 2'd0);
            end
          end
        endcase
      end
    end
  end

  assign a_raw     = (st_q == S_WR) ? dst_w[cur_q] : src_w[cur_q];
  assign mem_req   = (st_q != S_IDLE);
  assign mem_we    = (st_q == S_WR);
  assign mem_word  = cur_word;
  assign mem_addr  = cur_word ? (a_raw & ~AW'(3)) : a_raw;
  assign mem_wdata = cur_word ? hold_q : DW'(hold_q[15:0]);
  assign irq       = irq_q;

  for (genvar g = 0; g < NCH; g++) begin : g_ctl
    assign ctrl_o[CW*g +: CW] = ctl_q[g];
  end
endmodule

// File: rtl/blkxfer_dma_chk.sv
module blkxfer_dma_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_word,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ready,
  input logic [3:0]    irq,
  input logic [3:0]    ch_en,
  input logic [3:0]    ch_rep
);
  assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  assert_write_follows_read_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we && mem_ready |=> mem_req && mem_we);

  assert_word_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_word |-> mem_addr[1:0] == 2'b00);

  assert_half_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !mem_addr[0]);

  assert_irq_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq));

  assert_irq_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    |irq |=> irq == 4'b0000);

  assert_irq_after_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    |irq |-> $past(mem_req && mem_we && mem_ready));

  for (genvar g = 0; g < 4; g++) begin : g_ch
    assert_disarm_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq[g] && !ch_rep[g] |-> !ch_en[g]);
  end
endmodule

bind blkxfer_dma blkxfer_dma_chk #(.AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mem_req  (mem_req),
  .mem_we   (mem_we),
  .mem_word (mem_word),
  .mem_addr (mem_addr),
  .mem_ready(mem_ready),
  .irq      (irq),
  .ch_en    ({ctrl_o[63], ctrl_o[47], ctrl_o[31], ctrl_o[15]}),
  .ch_rep   ({ctrl_o[57], ctrl_o[41], ctrl_o[25], ctrl_o[9]})
);

// File: tb/test_blkxfer_dma.sv
module test_blkxfer_dma;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_ch = '0;
  logic [1:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic [63:0] ctrl_o;
  logic        vblank = 1'b0;
  logic        hblank = 1'b0;
  logic [2:0]  spec_trig = '0;
  logic        mem_req, mem_we, mem_word;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_ready = 1'b1;
  logic [3:0]  irq;

  int nchk = 0;
  int nfail = 0;
  int nwr = 0;
  int cyc = 0;
  int lastwr = 0;
  int scnt = 0;
  logic stall_en = 1'b0;
  logic [31:0] wa [2048];
  logic [31:0] wd [2048];
  int icnt [4];
  int icyc [4];

  blkxfer_dma #(.AW(32), .DW(32), .CNT_W(6)) i_blkxfer_dma (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_ch(reg_ch), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .ctrl_o(ctrl_o), .vblank(vblank), .hblank(hblank),
    .spec_trig(spec_trig), .mem_req(mem_req), .mem_we(mem_we), .mem_word(mem_word),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
    .mem_rdata(mem_rdata), .irq(irq)
  );

  function automatic logic [31:0] memfn(input logic [31:0] a);
    return {~a[15:0], a[15:0]} ^ 32'h1357_2468;
  endfunction

  function automatic logic [31:0] stp(input int mode, input int w);
    logic [31:0] sz;
    sz = (w != 0) ? 32'd4 : 32'd2;
    if (mode == 1) return -sz;
    if (mode == 2) return 32'd0;
    return sz;
  endfunction

  assign mem_rdata = memfn(mem_addr);

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    scnt++;
    mem_ready = !stall_en || (scnt % 3 != 0);
  end

  initial begin
    for (int i = 0; i < 4; i++) begin
      icnt[i] = 0;
      icyc[i] = 0;
    end
  end

  always @(posedge clk) begin
    if (mem_req && mem_we && mem_ready && nwr < 2048) begin
      wa[nwr] = mem_addr;
      wd[nwr] = mem_wdata;
      lastwr = cyc;
      nwr++;
    end
    for (int i = 0; i < 4; i++) begin
      if (irq[i]) begin
        icnt[i]++;
        icyc[i] = cyc;
      end
    end
    cyc++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int ch, input int sel, input logic [31:0] v);
    @(negedge clk);
    reg_we = 1'b1; reg_ch = ch[1:0]; reg_sel = sel[1:0]; reg_wdata = v;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_v();
    @(negedge clk); vblank = 1'b1; @(negedge clk); vblank = 1'b0;
  endtask

  task automatic pulse_h();
    @(negedge clk); hblank = 1'b1; @(negedge clk); hblank = 1'b0;
  endtask

  task automatic pulse_s(input logic [2:0] v);
    @(negedge clk); spec_trig = v; @(negedge clk); spec_trig = '0;
  endtask

  function automatic logic [15:0] ctl_of(input int ch);
    return ctrl_o[ch*16 +: 16];
  endfunction

  task automatic run_imm(input int ch, input logic [31:0] s, input logic [31:0] d,
                         input int cv, input int sc, input int dc, input int w, input bit ie);
    logic [15:0] cw;
    logic [31:0] sa, da, ss, ds, ea;
    int n, b, ib;
    cw = 16'h8815 | (16'(ie) << 14) | (16'(w) << 10) | (16'(sc) << 7) | (16'(dc) << 5);
    n  = (cv == 0) ? ((ch == 3) ? 64 : 16) : cv;
    b  = nwr;
    ib = icnt[ch];
    wr(ch, 0, s); wr(ch, 1, d); wr(ch, 2, cv); wr(ch, 3, {16'h0, cw});
    for (int t = 0; t < 4000 && nwr < b + n; t++) @(negedge clk);
    idle(3);
    chk((cv == 0) ? "R4 zero-count units" : "R12 unit count", nwr - b, n);
    sa = s & ~32'd1; da = d & ~32'd1;
    if (w != 0) begin sa = sa & ~32'd3; da = da & ~32'd3; end
    ss = stp(sc, w); ds = stp(dc, w);
    for (int k = 0; k < n; k++) begin
      ea = sa + 32'(k) * ss;
      chk("R2/R3 dst address", wa[b+k], da + 32'(k) * ds);
      chk("R3/R12 data from src", wd[b+k], (w != 0) ? memfn(ea) : (memfn(ea) & 32'h0000_FFFF));
    end
    chk("R8 control after block", {16'h0, ctl_of(ch)}, {16'h0, cw & 16'h7FE0});
    chk("R10 irq count", icnt[ch] - ib, ie ? 1 : 0);
    if (ie) chk("R10 irq cycle", icyc[ch], lastwr + 1);
  endtask

  initial begin : main
    int b;
    idle(3);
    chk("R1 mem_req in reset", {31'h0, mem_req}, 32'h0);
    chk("R1 irq in reset", {28'h0, irq}, 32'h0);
    chk("R1 ctrl low in reset", ctrl_o[31:0], 32'h0);
    chk("R1 ctrl high in reset", ctrl_o[63:32], 32'h0);
    rst_n = 1'b1;
    idle(3);
    chk("R1 mem_req after reset", {31'h0, mem_req}, 32'h0);

    wr(1, 3, 32'h1234);
    idle(1);
    chk("R13 control readback", {16'h0, ctl_of(1)}, 32'h1234);
    wr(1, 3, 32'h0);

    for (int ch = 0; ch < 4; ch++)
      for (int sc = 0; sc < 4; sc++)
        for (int dc = 0; dc < 4; dc++)
          for (int w = 0; w < 2; w++) begin
            stall_en = (ch % 2 == 1);
            run_imm(ch, 32'h0001_0081 + 32'(ch) * 32'h1000 + 32'(sc) * 32'h100 + 32'(w) * 2,
                    32'h0002_0403 + 32'(ch) * 32'h1000 + 32'(dc) * 32'h100,
                    1 + (sc + dc + w) % 4, sc, dc, w, ((sc + dc) % 2) == 0);
          end
    stall_en = 1'b0;

    run_imm(0, 32'h0003_0000, 32'h0004_0000, 0, 0, 0, 0, 1'b1);
    run_imm(2, 32'h0003_1000, 32'h0004_1000, 0, 0, 0, 1, 1'b0);
    run_imm(3, 32'h0003_2000, 32'h0004_2000, 0, 0, 0, 1, 1'b1);

    b = nwr;
    wr(0, 0, 32'h100); wr(0, 1, 32'h4000); wr(0, 2, 2); wr(0, 3, 32'h8000 | 32'h2000);
    wr(1, 0, 32'h140); wr(1, 1, 32'h5000); wr(1, 2, 2); wr(1, 3, 32'h8000 | 32'h1000);
    wr(2, 0, 32'h180); wr(2, 1, 32'h6000); wr(2, 2, 2); wr(2, 3, 32'h8000 | 32'h1000);
    idle(20);
    chk("R6 waiting channels idle", nwr - b, 0);
    pulse_h();
    idle(20);
    chk("R6 hblank runs only ch0", nwr - b, 2);
    chk("R6 hblank ch0 address", wa[b], 32'h4000);
    pulse_v();
    idle(30);
    chk("R6 vblank units", nwr - b, 6);
    chk("R6 vblank ch1 first", wa[b+2], 32'h5000);
    chk("R6 vblank ch1 second unit", wa[b+3], 32'h5002);
    chk("R6 vblank ch2 after ch1", wa[b+4], 32'h6000);

    b = nwr;
    wr(0, 0, 32'h200); wr(0, 1, 32'h7000); wr(0, 2, 1); wr(0, 3, 32'h8000 | 32'h3000);
    pulse_v(); pulse_h(); pulse_s(3'b111);
    idle(20);
    chk("R7 ch0 special never runs", nwr - b, 0);
    chk("R7 ch0 stays enabled", {31'h0, ctl_of(0)[15]}, 32'h1);
    wr(0, 3, 32'h0);
    wr(2, 0, 32'h240); wr(2, 1, 32'h7100); wr(2, 2, 1); wr(2, 3, 32'h8000 | 32'h3000);
    idle(10);
    chk("R7 ch2 waits for its trigger", nwr - b, 0);
    pulse_s(3'b001);
    idle(10);
    chk("R7 other trigger bit ignored", nwr - b, 0);
    pulse_s(3'b010);
    idle(10);
    chk("R7 ch2 special runs", nwr - b, 1);
    chk("R7 ch2 special address", wa[b], 32'h7100);

    b = nwr;
    wr(1, 0, 32'h200); wr(1, 1, 32'h8000); wr(1, 2, 1); wr(1, 3, 32'h8000 | 32'h1000);
    wr(1, 0, 32'h300);
    wr(1, 3, 32'h8000 | 32'h1000);
    pulse_v();
    idle(10);
    chk("R5 one unit", nwr - b, 1);
    chk("R5 enable rewrite keeps source", wd[b], memfn(32'h200) & 32'hFFFF);
    wr(3, 0, 32'h280); wr(3, 1, 32'h8100); wr(3, 2, 1); wr(3, 3, 32'h8000 | 32'h1000);
    wr(3, 3, 32'h0000 | 32'h1000);
    pulse_v();
    idle(10);
    chk("R5 disabled channel ignores trigger", nwr - b, 1);

    b = nwr;
    wr(1, 0, 32'h400); wr(1, 1, 32'h9000); wr(1, 2, 2); wr(1, 3, 32'hA260);
    pulse_h(); idle(30); pulse_h(); idle(30);
    chk("R9 reload units", nwr - b, 4);
    chk("R9 reload dst first", wa[b+2], 32'h9000);
    chk("R9 reload dst second", wa[b+3], 32'h9002);
    chk("R9 source continues", wd[b+2], memfn(32'h404) & 32'hFFFF);
    chk("R9 source continues 2", wd[b+3], memfn(32'h406) & 32'hFFFF);
    chk("R9 stays enabled", {16'h0, ctl_of(1)}, 32'hA260);
    wr(1, 3, 32'h0);
    pulse_h(); idle(20);
    chk("R5 disarmed repeat channel quiet", nwr - b, 4);
    b = nwr;
    wr(2, 0, 32'h500); wr(2, 1, 32'hA000); wr(2, 2, 2); wr(2, 3, 32'hA200);
    pulse_h(); idle(30); pulse_h(); idle(30);
    chk("R9 dst continues units", nwr - b, 4);
    chk("R9 dst continues", wa[b+2], 32'hA004);
    chk("R9 dst continues 2", wa[b+3], 32'hA006);
    wr(2, 3, 32'h0);

    stall_en = 1'b1;
    b = nwr;
    wr(0, 0, 32'h700); wr(0, 1, 32'hC000); wr(0, 2, 2);
    wr(2, 0, 32'h600); wr(2, 1, 32'hB000); wr(2, 2, 4);
    wr(2, 3, 32'h8000);
    wr(0, 3, 32'h8000);
    idle(100);
    chk("R11 total units", nwr - b, 6);
    for (int k = 0; k < 4; k++) chk("R11 running block completes", wa[b+k], 32'hB000 + 32'(2*k));
    chk("R11 ch0 after", wa[b+4], 32'hC000);
    chk("R11 ch0 after 2", wa[b+5], 32'hC002);
    stall_en = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog: actual %0d expected %0d cycles", 150000, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end
endmodule